// File: doc/BRIEF.md
# Leaky Square-and-Multiply Modular Exponentiator

This block computes `base ^ exponent mod modulus` with the left-to-right binary method, and it keeps the data-dependent control flow on purpose. The accumulator starts at 1. For each exponent bit, taken from the most significant end, the engine squares the accumulator and reduces it. Only when the bit is 1 does it then multiply by the base and reduce a second time. A 0 bit therefore costs two steps and a 1 bit costs four. Total run time, and the switching pattern seen on the supply, follow the exponent's bit pattern directly. The block is a test article for side-channel experiments, not a hardened primitive.

A built-in clock-enable divider makes the engine take one step every `CLK_DIV` reference cycles, so each step is long enough to see on a supply trace. A single `start` pulse launches one run. With `repeatMode` held high, the engine restarts as soon as a run ends, using the exponent rotated left by one place. This gives a periodic activity pattern that can be watched on a scope.

Top module: `modexp_leaky`

## Requirements
- R1: While reset is asserted and after its release, `result` is 0 and `done` is 0 until the first run completes.
- R2: A run started by `start` in the idle state produces `result` = base^exponent mod modulus, with the exponent treated as an unsigned 8-bit value. A zero exponent gives 1 when the modulus is at least 2.
- R3: `done` first reads high exactly `CLK_DIV * (2*EXP_W + 2*popcount(exponent))` reference cycles after the clock edge that samples `start`. Each exponent bit takes two steps, plus two more when the bit is 1.
- R4: `done` is high for exactly one cycle per completed run. `result` changes only together with that pulse and otherwise holds its last value.
- R5: A modulus of 0 or 1 yields a result of 0.
- R6: A `start` pulse while a run is in progress has no effect on that run's result or completion time.
- R7: Base, exponent and modulus are captured on the edge that samples `start`. Changes to those inputs during a run have no effect on the result.
- R8: With `repeatMode` high at the end of a run, the next run begins without `start`. It uses the previous exponent rotated left by one place (bit 7 moves to bit 0). Successive `done` pulses are `CLK_DIV * steps` cycles apart.
- R9: When `repeatMode` is low at the end of a run, the engine returns to idle and raises no further `done` pulse.
- R10: Every arithmetic step (square, multiply, reduce) happens only on a divider tick, so no two steps are closer than `CLK_DIV` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a run when idle |
| repeatMode | input | 1 | Keep re-running with the exponent rotated |
| baseIn | input | DATA_W | Base operand |
| expIn | input | EXP_W | Exponent operand |
| modIn | input | DATA_W | Modulus operand |
| result | output | DATA_W | Last completed result |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `CLK_DIV = 3`, together with the default 16-bit data and 8-bit exponent. With that divider, runs of up to 32 steps finish within about a hundred cycles. Every vector can then be checked for both its value and its exact cycle count, and several rotated repeat periods fit into one short run. The small divider ratio still keeps steps more than one cycle apart. This exposes any step that fires off a tick or any miscount in the divider phase after `start`.

// File: rtl/modexp_pkg.sv
`timescale 1ns/1ps
package modexp_pkg;
  // Step strobes from control to datapath; at most one arithmetic strobe per cycle.
  typedef struct packed {
    logic load;    // capture operands, accumulator <= 1
    logic sqr;     // product <= acc * acc
    logic mul;     // product <= acc * base
    logic red;     // acc <= product mod modulus
    logic finish;  // publish reduced value, pulse done
    logic rotate;  // rotate exponent, accumulator <= 1 for the next run
  } stepCtl_t;
endpackage

// File: rtl/modexp_tick.sv
`timescale 1ns/1ps
module modexp_tick #(
  parameter int CLK_DIV = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(CLK_DIV);
      localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/modexp_ctrl.sv
`timescale 1ns/1ps
module modexp_ctrl
  import modexp_pkg::*;
#(
  parameter int EXP_W = 8,
  localparam int IW = (EXP_W > 1) ? $clog2(EXP_W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          repeatMode,
  input  logic          tick,
  input  logic          curBit,
  output stepCtl_t      ctl,
  output logic          divClr,
  output logic [IW-1:0] bitIdx
);
  typedef enum logic [2:0] {S_IDLE, S_SQR, S_RED1, S_MUL, S_RED2} state_t;
  localparam logic [IW-1:0] TOP_IDX = IW'(EXP_W - 1);

  state_t state, nextState;
  logic [IW-1:0] nextIdx;
  logic bitEnd;

  always_comb begin
    ctl = '0;
    nextState = state;
    nextIdx = bitIdx;
    bitEnd = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.load = 1'b1;
        nextIdx = TOP_IDX;
        nextState = S_SQR;
      end
      S_SQR: if (tick) begin
        ctl.sqr = 1'b1;
        nextState = S_RED1;
      end
      S_RED1: if (tick) begin
        ctl.red = 1'b1;
        if (curBit) nextState = S_MUL;
        else bitEnd = 1'b1;
      end
      S_MUL: if (tick) begin
        ctl.mul = 1'b1;
        nextState = S_RED2;
      end
      S_RED2: if (tick) begin
        ctl.red = 1'b1;
        bitEnd = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
    if (bitEnd) begin
      if (bitIdx == '0) begin
        ctl.finish = 1'b1;
        if (repeatMode) begin
          ctl.rotate = 1'b1;
          nextIdx = TOP_IDX;
          nextState = S_SQR;
        end else begin
          nextState = S_IDLE;
        end
      end else begin
        nextIdx = bitIdx - 1'b1;
        nextState = S_SQR;
      end
    end
  end

  assign divClr = ctl.load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      bitIdx <= '0;
    end else begin
      state  <= nextState;
      bitIdx <= nextIdx;
    end
  end
endmodule

// File: rtl/modexp_dpath.sv
`timescale 1ns/1ps
module modexp_dpath
  import modexp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXP_W = 8,
  localparam int PW = 2 * DATA_W,
  localparam int IW = (EXP_W > 1) ? $clog2(EXP_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stepCtl_t          ctl,
  input  logic [DATA_W-1:0] baseIn,
  input  logic [EXP_W-1:0]  expIn,
  input  logic [DATA_W-1:0] modIn,
  input  logic [IW-1:0]     bitIdx,
  output logic              curBit,
  output logic [DATA_W-1:0] modQ,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic [DATA_W-1:0] baseQ, accQ, redVal;
  logic [EXP_W-1:0]  expQ;
  logic [PW-1:0]     prodQ, remFull;
  logic              modTrivial;

  assign curBit = expQ[bitIdx];
  assign modTrivial = (modQ <= DATA_W'(1));
  assign remFull = modTrivial ? '0 : (prodQ % PW'(modQ));
  assign redVal = remFull[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ  <= '0;
      modQ   <= '0;
      expQ   <= '0;
      accQ   <= '0;
      prodQ  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (ctl.load) begin
        baseQ <= baseIn;
        modQ  <= modIn;
        expQ  <= expIn;
        accQ  <= DATA_W'(1);
        prodQ <= '0;
      end
      if (ctl.sqr) prodQ <= PW'(accQ) * PW'(accQ);
      if (ctl.mul) prodQ <= PW'(accQ) * PW'(baseQ);
      if (ctl.red) accQ <= redVal;
      if (ctl.finish) result <= redVal;
      if (ctl.rotate) begin
        expQ <= {expQ[EXP_W-2:0], expQ[EXP_W-1]};
        accQ <= DATA_W'(1);
      end
    end
  end
endmodule

// File: rtl/modexp_leaky.sv
`timescale 1ns/1ps
module modexp_leaky
  import modexp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int EXP_W = 8,
  parameter int CLK_DIV = 2500,
  localparam int IW = (EXP_W > 1) ? $clog2(EXP_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              repeatMode,
  input  logic [DATA_W-1:0] baseIn,
  input  logic [EXP_W-1:0]  expIn,
  input  logic [DATA_W-1:0] modIn,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  stepCtl_t ctl;
  logic tick, divClr, curBit;
  logic [IW-1:0] bitIdx;
  logic [DATA_W-1:0] modQ;

  modexp_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(divClr), .tick(tick)
  );

  modexp_ctrl #(.EXP_W(EXP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .repeatMode(repeatMode),
    .tick(tick), .curBit(curBit), .ctl(ctl), .divClr(divClr), .bitIdx(bitIdx)
  );

  modexp_dpath #(.DATA_W(DATA_W), .EXP_W(EXP_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .baseIn(baseIn), .expIn(expIn),
    .modIn(modIn), .bitIdx(bitIdx), .curBit(curBit), .modQ(modQ),
    .result(result), .done(done)
  );
endmodule

// File: rtl/modexp_leaky_chk.sv
`timescale 1ns/1ps
module modexp_leaky_chk
  import modexp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic [DATA_W-1:0] modQ,
  input logic              tick,
  input stepCtl_t          ctl
);
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_moves_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  assert_result_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((modQ <= DATA_W'(1)) ? (result == '0) : (result < modQ)));

  assert_step_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sqr || ctl.mul || ctl.red) |-> tick);

  assert_one_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.load, ctl.sqr, ctl.mul, ctl.red}));

  assert_finish_on_reduce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.finish |-> ctl.red);
endmodule

bind modexp_leaky modexp_leaky_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .result(result),
  .modQ(modQ), .tick(tick), .ctl(ctl)
);

// File: tb/modexp_leaky_bench.sv
`timescale 1ns/1ps
module modexp_leaky_bench;
  localparam int DW = 16;
  localparam int EW = 8;
  localparam int DIV = 3;
  localparam int NV = 8;
  // {base, exponent, modulus}
  localparam logic [2*DW+EW-1:0] VEC [NV] = '{
    {16'd3,     8'd13,  16'd17},
    {16'd1234,  8'hFF,  16'd65521},
    {16'd7,     8'h00,  16'd100},
    {16'd5,     8'h80,  16'd1000},
    {16'd9,     8'hA5,  16'd0},
    {16'd9,     8'h5A,  16'd1},
    {16'd65534, 8'h01,  16'd65535},
    {16'd0,     8'h37,  16'd251}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, repeatMode = 1'b0;
  logic [DW-1:0] baseIn = '0, modIn = '0;
  logic [EW-1:0] expIn = '0;
  logic [DW-1:0] result;
  logic done;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  modexp_leaky #(.DATA_W(DW), .EXP_W(EW), .CLK_DIV(DIV)) u_modexp_leaky (
    .clk(clk), .rst_n(rst_n), .start(start), .repeatMode(repeatMode),
    .baseIn(baseIn), .expIn(expIn), .modIn(modIn), .result(result), .done(done)
  );

  function automatic logic [DW-1:0] refPow(logic [DW-1:0] b, logic [EW-1:0] e, logic [DW-1:0] m);
    logic [31:0] r;
    if (m <= 1) return '0;
    r = 32'd1;
    for (int k = 0; k < int'(e); k++) r = (r * {16'd0, b}) % {16'd0, m};
    return r[DW-1:0];
  endfunction

  function automatic int refCycles(logic [EW-1:0] e);
    return DIV * (2 * EW + 2 * $countones(e));
  endfunction

  function automatic logic [EW-1:0] rotl(logic [EW-1:0] e);
    return {e[EW-2:0], e[EW-1]};
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait edges after the current point until done is seen; returns edge count.
  task automatic waitDone(output int n);
    n = 0;
    do begin
      @(posedge clk); #2;
      n++;
    end while (!done && n < 2000);
  endtask

  task automatic launch(logic [DW-1:0] b, logic [EW-1:0] e, logic [DW-1:0] m);
    @(negedge clk);
    baseIn = b; expIn = e; modIn = m; start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int n;
    logic [EW-1:0] e;
    repeat (3) @(posedge clk);
    #2;
    check("R1 result in reset", result, 0);
    check("R1 done in reset", done, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    check("R1 result after reset", result, 0);
    check("R1 done after reset", done, 0);

    // Vector table: value (R2, R5) and exact timing (R3).
    for (int i = 0; i < NV; i++) begin
      logic [DW-1:0] vb, vm;
      logic [EW-1:0] ve;
      {vb, ve, vm} = VEC[i];
      launch(vb, ve, vm);
      waitDone(n);
      check((vm <= 1) ? "R5 trivial modulus" : "R2 result", result, refPow(vb, ve, vm));
      check("R3 cycle count", n, refCycles(ve));
      @(posedge clk); #2;
      check("R4 done one cycle", done, 0);
      repeat (4) @(posedge clk);
      #2;
      check("R4 result held", result, refPow(vb, ve, vm));
    end

    // R6/R7: start pulse and operand changes mid-run are ignored.
    launch(16'd11, 8'hC3, 16'd4093);
    repeat (10) @(posedge clk);
    @(negedge clk);
    baseIn = 16'd2; expIn = 8'h01; modIn = 16'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 11;
    while (!done && n < 2000) begin @(posedge clk); #2; n++; end
    check("R6 busy start ignored timing", n, refCycles(8'hC3));
    check("R7 operands held mid-run", result, refPow(16'd11, 8'hC3, 16'd4093));

    // R8: repeat mode with rotating exponent.
    e = 8'b1011_0001;
    @(negedge clk); repeatMode = 1'b1;
    launch(16'd6, e, 16'd9973);
    waitDone(n);
    check("R8 first run value", result, refPow(16'd6, e, 16'd9973));
    for (int r = 0; r < 3; r++) begin
      e = rotl(e);
      waitDone(n);
      check("R8 repeat period", n, refCycles(e));
      check("R8 rotated value", result, refPow(16'd6, e, 16'd9973));
    end
    // R9: drop repeat mode; current run completes, then idle.
    @(negedge clk); repeatMode = 1'b0;
    e = rotl(e);
    waitDone(n);
    check("R9 last run value", result, refPow(16'd6, e, 16'd9973));
    n = 0;
    repeat (3 * refCycles(8'hFF)) begin
      @(posedge clk); #2;
      if (done) n++;
    end
    check("R9 no further done", n, 0);
    check("R9 result stable when idle", result, refPow(16'd6, e, 16'd9973));

    // R10: steps spaced by the divider; e=0 takes 16 steps at DIV cycles each.
    launch(16'd3, 8'h00, 16'd5);
    waitDone(n);
    check("R10 step spacing", n, DIV * 16);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule